// File: doc/BRIEF.md
# Three-Operand Add/Subtract Overflow Detector

This block evaluates one of three two-step expressions on three 4-bit operands, `(x + y) - z`, `(x - y) - z` or `x - (y + z)`, using two chained adder stages. Each stage either adds, or subtracts by inverting its second operand and forcing its carry-in to one. The second stage always subtracts. The block presents the wrapped result and the two carries of each stage: the carry into the top bit and the carry out of the top bit. It also presents one overall overflow flag, computed under an unsigned or a two's-complement reading of the operands.

A stage whose result wraps leaves a value error of plus or minus 16 in its output. The block assigns each stage a signed error count from its carries and the active mode. It negates the first stage's count when that stage's result enters the second stage as the subtrahend. It then raises the flag only if the net count is nonzero. So when one stage wraps upward and the other wraps downward, the final result is exact and no overflow is reported. The outputs are registered once, so results appear one clock after the inputs are sampled.

Top module: `tod_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is zero after that edge.
- R2: Outputs show the result for the inputs sampled at the previous rising edge, so the latency is exactly one clock.
- R3: `op` = 2'b00 gives `r` = (x+y)-z, 2'b01 gives (x-y)-z and 2'b10 gives x-(y+z), each modulo 16. `op` = 2'b11 behaves exactly as 2'b00.
- R4: Stage 1 computes x plus y for op 00 and 11, x plus (not y) plus 1 for op 01, and y plus z for op 10. `s1_cmsb` is its carry into bit 3 and `s1_cout` is its carry out of bit 3.
- R5: Stage 2 always subtracts. Its minuend is the stage 1 sum and its subtrahend is z, except for op 10, where the minuend is x and the subtrahend is the stage 1 sum. `s2_cmsb` and `s2_cout` carry the same meaning as in R4.
- R6: With `signed_mode` low, `ovf` is 1 exactly when the exact integer value of the selected expression, with operands read as 0..15, lies outside 0..15.
- R7: With `signed_mode` high, `ovf` is 1 exactly when the exact value, with operands read as two's complement -8..7, lies outside -8..7.
- R8: With `signed_mode` high, `ovf` is never 1 unless at least one stage has unequal `cmsb` and `cout`.
- R9: When both stages wrap in opposite directions, `ovf` stays 0. For example, unsigned op 00 with x=12, y=8, z=6 gives r=14, and signed op 00 with x=y=z=7 gives r=7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| x | input | 4 | First operand |
| y | input | 4 | Second operand |
| z | input | 4 | Third operand |
| op | input | 2 | Expression select (see R3) |
| signed_mode | input | 1 | 1: two's-complement reading, 0: unsigned reading |
| r | output | 4 | Wrapped result |
| s1_cmsb | output | 1 | Stage 1 carry into its top bit |
| s1_cout | output | 1 | Stage 1 carry out of its top bit |
| s2_cmsb | output | 1 | Stage 2 carry into its top bit |
| s2_cout | output | 1 | Stage 2 carry out of its top bit |
| ovf | output | 1 | Overall overflow for the selected reading |

## Verification
On every cycle after reset, the properties compare the result, the stage 1 carry-out and the overflow flag in both modes against exact integer arithmetic on the inputs of the previous cycle. They also check that a signed overflow is always backed by a mismatched carry pair. The bench sweeps every operand triple for every op code in both modes. Only its directed vectors show the reset state and the cancellation cases, where both stages wrap yet the flag stays low. The stage 2 carries are checked only by the bench.

// File: rtl/tod_pkg.sv
package tod_pkg;

    typedef enum logic [1:0] {
        OP_ADD_SUB = 2'b00,
        OP_SUB_SUB = 2'b01,
        OP_SUB_ADD = 2'b10,
        OP_ALIAS   = 2'b11
    } tod_op_e;

    typedef struct packed {
        logic c_msb;
        logic c_out;
    } carry_pair_t;

    // Wrap count of one stage in units of 2**W: +1 means the stored value
    // is 2**W below the exact value, -1 means it is 2**W above.
    function automatic logic signed [2:0] stage_err(input logic sgn,
                                                   input logic sub,
                                                   input carry_pair_t c);
        logic signed [2:0] e;
        e = 3'sd0;
        if (sgn) begin
            if (c.c_msb && !c.c_out)      e = 3'sd1;
            else if (!c.c_msb && c.c_out) e = -3'sd1;
        end else if (sub) begin
            if (!c.c_out) e = -3'sd1;
        end else begin
            if (c.c_out) e = 3'sd1;
        end
        return e;
    endfunction

endpackage

// File: rtl/tod_stage.sv
module tod_stage #(
    parameter int W = 4
) (
    input  logic [W-1:0]         a,
    input  logic [W-1:0]         b,
    input  logic                 sub,
    output logic [W-1:0]         sum,
    output tod_pkg::carry_pair_t carries
);
    logic [W-1:0] b_eff;
    logic [W-1:0] low_part;
    logic [W:0]   full_part;

    assign b_eff     = sub ? ~b : b;
    assign low_part  = {1'b0, a[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, sub};
    assign full_part = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};

    assign sum           = full_part[W-1:0];
    assign carries.c_msb = low_part[W-1];
    assign carries.c_out = full_part[W];
endmodule

// File: rtl/tod_judge.sv
module tod_judge (
    input  logic                 sgn,
    input  logic                 s1_sub,
    input  logic                 s1_negated,
    input  tod_pkg::carry_pair_t c1,
    input  tod_pkg::carry_pair_t c2,
    output logic                 ovf
);
    import tod_pkg::*;

    logic signed [2:0] e1;
    logic signed [2:0] e2;
    logic signed [2:0] net;

    always_comb begin
        e1  = stage_err(sgn, s1_sub, c1);
        e2  = stage_err(sgn, 1'b1, c2);
        net = s1_negated ? (e2 - e1) : (e2 + e1);
        ovf = (net != 3'sd0);
    end
endmodule

// File: rtl/tod_core.sv
module tod_core #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    input  logic [1:0]   op,
    input  logic         signed_mode,
    output logic [W-1:0] r,
    output logic         s1_cmsb,
    output logic         s1_cout,
    output logic         s2_cmsb,
    output logic         s2_cout,
    output logic         ovf
);
    import tod_pkg::*;

    tod_op_e     op_e;
    logic [W-1:0] s1_a, s1_b, s1_sum;
    logic [W-1:0] s2_a, s2_b, s2_sum;
    logic        s1_sub, s1_negated;
    carry_pair_t c1, c2;
    logic        ovf_c;

    assign op_e = tod_op_e'(op);

    always_comb begin
        s1_a       = x;
        s1_b       = y;
        s1_sub     = 1'b0;
        s1_negated = 1'b0;
        s2_a       = s1_sum;
        s2_b       = z;
        case (op_e)
            OP_SUB_SUB: s1_sub = 1'b1;
            OP_SUB_ADD: begin
                s1_a       = y;
                s1_b       = z;
                s1_negated = 1'b1;
                s2_a       = x;
                s2_b       = s1_sum;
            end
            default: ;
        endcase
    end

    tod_stage #(.W(W)) stage1_i (
        .a(s1_a), .b(s1_b), .sub(s1_sub), .sum(s1_sum), .carries(c1)
    );

    tod_stage #(.W(W)) stage2_i (
        .a(s2_a), .b(s2_b), .sub(1'b1), .sum(s2_sum), .carries(c2)
    );

    tod_judge judge_i (
        .sgn(signed_mode), .s1_sub(s1_sub), .s1_negated(s1_negated),
        .c1(c1), .c2(c2), .ovf(ovf_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            r       <= '0;
            s1_cmsb <= 1'b0;
            s1_cout <= 1'b0;
            s2_cmsb <= 1'b0;
            s2_cout <= 1'b0;
            ovf     <= 1'b0;
        end else begin
            r       <= s2_sum;
            s1_cmsb <= c1.c_msb;
            s1_cout <= c1.c_out;
            s2_cmsb <= c2.c_msb;
            s2_cout <= c2.c_out;
            ovf     <= ovf_c;
        end
    end
endmodule

// File: rtl/tod_core_chk.sv
module tod_core_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] x,
    input logic [W-1:0] y,
    input logic [W-1:0] z,
    input logic [1:0]   op,
    input logic         signed_mode,
    input logic [W-1:0] r,
    input logic         s1_cmsb,
    input logic         s1_cout,
    input logic         s2_cmsb,
    input logic         s2_cout,
    input logic         ovf
);
    localparam int UMAX = (1 << W) - 1;
    localparam int SMAX = (1 << (W - 1)) - 1;
    localparam int SMIN = -(1 << (W - 1));

    int   xu, yu, zu, xs, ys, zs, eu, es;
    logic c1o_m;
    logic armed, p_sgn, p_c1o;
    int   p_eu, p_es;

    always_comb begin
        xu = int'(x);
        yu = int'(y);
        zu = int'(z);
        xs = int'($signed(x));
        ys = int'($signed(y));
        zs = int'($signed(z));
        case (op)
            2'b01:   begin eu = xu - yu - zu;   es = xs - ys - zs;   c1o_m = (xu >= yu);        end
            2'b10:   begin eu = xu - (yu + zu); es = xs - (ys + zs); c1o_m = (yu + zu > UMAX);  end
            default: begin eu = xu + yu - zu;   es = xs + ys - zs;   c1o_m = (xu + yu > UMAX);  end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            p_sgn <= 1'b0;
            p_c1o <= 1'b0;
            p_eu  <= 0;
            p_es  <= 0;
        end else begin
            armed <= 1'b1;
            p_sgn <= signed_mode;
            p_c1o <= c1o_m;
            p_eu  <= eu;
            p_es  <= es;
        end
    end

    AST_RESULT_WRAP: assert property (@(posedge clk) disable iff (rst)
        armed |-> (r == p_eu[W-1:0])); // R3

    AST_S1_CARRY_OUT: assert property (@(posedge clk) disable iff (rst)
        armed |-> (s1_cout == p_c1o)); // R4

    AST_UNSIGNED_FLAG: assert property (@(posedge clk) disable iff (rst)
        (armed && !p_sgn) |-> (ovf == (p_eu < 0 || p_eu > UMAX))); // R6

    AST_SIGNED_FLAG: assert property (@(posedge clk) disable iff (rst)
        (armed && p_sgn) |-> (ovf == (p_es < SMIN || p_es > SMAX))); // R7

    AST_SIGNED_NEEDS_STAGE: assert property (@(posedge clk) disable iff (rst)
        (armed && p_sgn && ovf) |-> ((s1_cmsb != s1_cout) || (s2_cmsb != s2_cout))); // R8

endmodule

bind tod_core tod_core_chk #(.W(W)) chk_i (
    .clk(clk), .rst(rst), .x(x), .y(y), .z(z), .op(op),
    .signed_mode(signed_mode), .r(r), .s1_cmsb(s1_cmsb), .s1_cout(s1_cout),
    .s2_cmsb(s2_cmsb), .s2_cout(s2_cout), .ovf(ovf)
);

// File: tb/tod_core_tb_top.sv
module tod_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;
    localparam int MASK       = (1 << W) - 1;
    localparam int LMASK      = (1 << (W - 1)) - 1;

    typedef struct {
        int r;
        bit c1m, c1o, c2m, c2o, ov, sgn;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] x = '0, y = '0, z = '0;
    logic [1:0]   op = 2'b00;
    logic         signed_mode = 1'b0;
    logic [W-1:0] r;
    logic         s1_cmsb, s1_cout, s2_cmsb, s2_cout, ovf;

    int   total = 0;
    int   bad   = 0;
    exp_t exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    tod_core #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .x(x), .y(y), .z(z), .op(op),
        .signed_mode(signed_mode), .r(r), .s1_cmsb(s1_cmsb), .s1_cout(s1_cout),
        .s2_cmsb(s2_cmsb), .s2_cout(s2_cout), .ovf(ovf)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int stage(input int a, input int b, input bit sub,
                                 output bit cm, output bit co);
        int bb;
        int tot;
        bb  = sub ? (MASK - b) : b;
        tot = a + bb + int'(sub);
        co  = ((tot >> W) & 1) != 0;
        cm  = ((((a & LMASK) + (bb & LMASK) + int'(sub)) >> (W - 1)) & 1) != 0;
        return tot & MASK;
    endfunction

    function automatic int sx(input int v);
        return (v > LMASK) ? v - (1 << W) : v;
    endfunction

    function automatic exp_t model(input int xv, input int yv, input int zv,
                                   input int opv, input bit sgn);
        exp_t e;
        int s1, eu, es;
        bit m1, o1, m2, o2;
        if (opv == 2) begin
            s1 = stage(yv, zv, 1'b0, m1, o1);
            e.r = stage(xv, s1, 1'b1, m2, o2);
            eu = xv - (yv + zv);
            es = sx(xv) - (sx(yv) + sx(zv));
        end else begin
            s1 = stage(xv, yv, opv == 1, m1, o1);
            e.r = stage(s1, zv, 1'b1, m2, o2);
            eu = (opv == 1) ? xv - yv - zv : xv + yv - zv;
            es = (opv == 1) ? sx(xv) - sx(yv) - sx(zv) : sx(xv) + sx(yv) - sx(zv);
        end
        e.c1m = m1; e.c1o = o1; e.c2m = m2; e.c2o = o2; e.sgn = sgn;
        e.ov  = sgn ? (es < -(LMASK + 1) || es > LMASK) : (eu < 0 || eu > MASK);
        return e;
    endfunction

    task automatic compare_pending();
        exp_t e;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        check(int'(r) == e.r, "R3 R2 result", int'(r), e.r);
        check({s1_cmsb, s1_cout} == {e.c1m, e.c1o}, "R4 stage1 carries",
              int'({s1_cmsb, s1_cout}), int'({e.c1m, e.c1o}));
        check({s2_cmsb, s2_cout} == {e.c2m, e.c2o}, "R5 stage2 carries",
              int'({s2_cmsb, s2_cout}), int'({e.c2m, e.c2o}));
        if (e.sgn) begin
            check(ovf == e.ov, "R7 signed flag", int'(ovf), int'(e.ov));
            if (ovf)
                check((s1_cmsb != s1_cout) || (s2_cmsb != s2_cout), "R8 stage backing",
                      int'({s1_cmsb, s1_cout, s2_cmsb, s2_cout}), 1);
        end else begin
            check(ovf == e.ov, "R6 unsigned flag", int'(ovf), int'(e.ov));
        end
    endtask

    // Called at a falling edge: check the previous vector, then drive a new one.
    task automatic apply(input int xv, input int yv, input int zv, input int opv, input bit sgn);
        compare_pending();
        x = W'(xv); y = W'(yv); z = W'(zv); op = 2'(opv); signed_mode = sgn;
        exp_q.push_back(model(xv, yv, zv, opv, sgn));
        @(negedge clk);
    endtask

    initial begin
        // R1: reset clears outputs even with live inputs
        @(negedge clk);
        x = 4'd9; y = 4'd9; z = 4'd1; op = 2'b10; signed_mode = 1'b1;
        @(negedge clk);
        check(r == '0, "R1 reset result", int'(r), 0);
        check({s1_cmsb, s1_cout, s2_cmsb, s2_cout, ovf} == 5'b0, "R1 reset flags",
              int'({s1_cmsb, s1_cout, s2_cmsb, s2_cout, ovf}), 0);
        rst = 1'b0;

        // R9: opposite wraps cancel
        apply(12, 8, 6, 0, 1'b0);
        check(r == 4'd14 && ovf == 1'b0 && s1_cout && !s2_cout, "R9 unsigned cancel",
              int'({ovf, r}), 14);
        apply(7, 7, 7, 0, 1'b1);
        check(r == 4'd7 && ovf == 1'b0 && s1_cmsb && !s1_cout && !s2_cmsb && s2_cout,
              "R9 signed cancel", int'({ovf, r}), 7);
        apply(0, 0, 0, 0, 1'b0);

        // Full sweep; op 3 exercises the alias of R3
        for (int sg = 0; sg < 2; sg++)
            for (int o = 0; o < 4; o++)
                for (int a = 0; a <= MASK; a++)
                    for (int b = 0; b <= MASK; b++)
                        for (int c = 0; c <= MASK; c++)
                            apply(a, b, c, o, sg[0]);
        compare_pending();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule